// File: doc/BRIEF.md
# Dual-Port RAM with Busy Arbitration

A synchronous memory with two fully independent access ports, called left and right. Each port has its own address, write data, registered read data with a valid flag, a read/write strobe, an active-low output enable, a pair of chip enables of opposite polarity, and an active-low semaphore select. A port reaches the array only while its semaphore select is high. With the select low the port makes no access, because the semaphore bank is not part of this block.

When both ports reach the same word in the same cycle and at least one of them writes, an arbiter picks the port that was there first. The other port sees busy, and its write is dropped. A master/slave strap chooses the busy mode. In master mode, arbitration runs locally and busy is driven out. In slave mode, local busy outputs stay low, and each port's write is gated by a busy input from a master device. This lets several devices be placed side by side to form a wider word with a single arbitration decision. The array depth is set by `ADDR_W`: 16 gives 64K words of 8 bits, and the default build uses a smaller depth.

Top module: `dpr_busy_top`

## Requirements
- R1: A port is selected only when its `en_n` input is 0 and its `en_p` input is 1. With any other combination, the port writes nothing, and in the next cycle its `rvalid_o` is 0 and its `rdata_o` is 0.
- R2: A selected port with `sem_ni`=1 and `rw_i`=0 writes `wdata_i` to the word at `addr_i` at the clock edge, unless R9 or R10 blocks the write.
- R3: A selected port with `sem_ni`=1, `rw_i`=1 and `oe_ni`=0 presents the addressed word on `rdata_o` one clock later, with `rvalid_o`=1.
- R4: When `oe_ni`=1, the port's `rvalid_o` is 0 and its `rdata_o` is 0 in the next cycle, whatever the other inputs are.
- R5: With `sem_ni`=0, a port makes no memory access: it does no write, produces no valid read, and takes no part in contention.
- R6: Both ports may read the same word in the same cycle. Both get the word, and neither sees busy.
- R7: In master mode (`master_i`=1), a clash occurs when both ports access the same address and at least one of them writes. In a clash, the port that arrived later has its `busy_o` at 1 in that same cycle. A port counts as having arrived earlier if it accessed that same address in the previous cycle and the other port did not.
- R8: When neither port arrived earlier, including simultaneous arrival, the left port wins and only `r_busy_o` is 1. The two busy outputs are never 1 together.
- R9: In master mode, the losing port's write is blocked, and the winning port's write takes effect.
- R10: In slave mode (`master_i`=0), both `busy_o` outputs are 0. A port's write is blocked while its `busy_i` is 1. If neither write is blocked and both target one word, the left data is stored.
- R11: In master mode, `busy_i` has no effect on writes.
- R12: A read returns the word as it was before any write made in the same cycle by the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1: busy is generated locally; 0: busy comes from the inputs |
| l_addr_i | input | ADDR_W | Left address |
| l_wdata_i | input | DATA_W | Left write data |
| l_rw_i | input | 1 | Left strobe: 1 read, 0 write |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_en_n_i | input | 1 | Left chip enable, active low |
| l_en_p_i | input | 1 | Left chip enable, active high |
| l_sem_ni | input | 1 | Left semaphore select, active low; memory access only when 1 |
| l_busy_i | input | 1 | Left busy from a master (slave mode) |
| l_busy_o | output | 1 | Left busy (master mode) |
| l_rdata_o | output | DATA_W | Left read data, registered |
| l_rvalid_o | output | 1 | Left read data valid |
| r_addr_i | input | ADDR_W | Right address |
| r_wdata_i | input | DATA_W | Right write data |
| r_rw_i | input | 1 | Right strobe: 1 read, 0 write |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_en_n_i | input | 1 | Right chip enable, active low |
| r_en_p_i | input | 1 | Right chip enable, active high |
| r_sem_ni | input | 1 | Right semaphore select, active low |
| r_busy_i | input | 1 | Right busy from a master (slave mode) |
| r_busy_o | output | 1 | Right busy (master mode) |
| r_rdata_o | output | DATA_W | Right read data, registered |
| r_rvalid_o | output | 1 | Right read data valid |

## Verification
A write on one port and an access on the other port can land on the same word in the same cycle. Arbitration and the memory update then interact: busy has to go to the correct port, the losing write has to vanish, and a concurrent read has to return the old word. The bench provokes this with directed same-address pairs: simultaneous arrival, the left port holding an address while the right arrives, the reverse, and the same cases in slave mode with busy inputs. It then runs a long random phase on a four-word address window with a random strap, so clashes are frequent. A behavioural model judges busy in every cycle and judges the read data one clock later, including later reads of words a blocked write must not have changed.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned NPORT = 2;
  localparam int unsigned PL    = 0;
  localparam int unsigned PR    = 1;

  typedef struct packed {
    logic act;  // port reaches the array this cycle
    logic wr;
    logic rd;
  } port_req_t;
endpackage

// File: rtl/dpr_port_dec.sv
module dpr_port_dec
  import dpr_pkg::*;
(
  input  logic      en_n_i,
  input  logic      en_p_i,
  input  logic      sem_ni,
  input  logic      rw_i,
  input  logic      oe_ni,
  output port_req_t req_o
);
  logic sel;
  assign sel = ~en_n_i & en_p_i;

  always_comb begin
    req_o.act = sel & sem_ni;
    req_o.wr  = sel & sem_ni & ~rw_i;
    req_o.rd  = sel & sem_ni & rw_i & ~oe_ni;
  end
endmodule

// File: rtl/dpr_arb.sv
module dpr_arb
  import dpr_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       master_i,
  input  port_req_t [NPORT-1:0]      req_i,
  input  logic [NPORT-1:0][AW-1:0]   addr_i,
  input  logic [NPORT-1:0]           busy_i,
  output logic [NPORT-1:0]           busy_o,
  output logic [NPORT-1:0]           wr_ok_o
);
  logic [NPORT-1:0]         prev_act_q;
  logic [NPORT-1:0][AW-1:0] prev_addr_q;
  logic [NPORT-1:0]         held;
  logic [NPORT-1:0]         lose;
  logic                     clash;

  assign clash = req_i[PL].act & req_i[PR].act & (addr_i[PL] == addr_i[PR])
               & (req_i[PL].wr | req_i[PR].wr);

  // right wins only when it alone was already on this word
  assign lose[PL] = clash & held[PR] & ~held[PL];
  assign lose[PR] = clash & ~lose[PL];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign held[g] = prev_act_q[g] & (prev_addr_q[g] == addr_i[g]);

    always_comb begin
      busy_o[g]  = master_i & lose[g];
      wr_ok_o[g] = req_i[g].wr & (master_i ? ~lose[g] : ~busy_i[g]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_act_q[g]  <= 1'b0;
        prev_addr_q[g] <= '0;
      end else begin
        prev_act_q[g]  <= req_i[g].act;
        prev_addr_q[g] <= addr_i[g];
      end
    end
  end
endmodule

// File: rtl/dpr_mem.sv
module dpr_mem
  import dpr_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NPORT-1:0]         we_i,
  input  logic [NPORT-1:0]         re_i,
  input  logic [NPORT-1:0][AW-1:0] addr_i,
  input  logic [NPORT-1:0][DW-1:0] wdata_i,
  output logic [NPORT-1:0][DW-1:0] rdata_o,
  output logic [NPORT-1:0]         rvalid_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // left written last so it wins an unarbitrated same-word pair
  always_ff @(posedge clk_i) begin
    if (we_i[PR]) mem_q[addr_i[PR]] <= wdata_i[PR];
    if (we_i[PL]) mem_q[addr_i[PL]] <= wdata_i[PL];
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdata_o[g]  <= '0;
        rvalid_o[g] <= 1'b0;
      end else begin
        rdata_o[g]  <= re_i[g] ? mem_q[addr_i[g]] : '0;
        rvalid_o[g] <= re_i[g];
      end
    end
  end
endmodule

// File: rtl/dpr_busy_top.sv
module dpr_busy_top
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              l_rw_i,
  input  logic              l_oe_ni,
  input  logic              l_en_n_i,
  input  logic              l_en_p_i,
  input  logic              l_sem_ni,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_rvalid_o,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic              r_rw_i,
  input  logic              r_oe_ni,
  input  logic              r_en_n_i,
  input  logic              r_en_p_i,
  input  logic              r_sem_ni,
  input  logic              r_busy_i,
  output logic              r_busy_o,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_rvalid_o
);
  port_req_t [NPORT-1:0]          req;
  logic [NPORT-1:0][ADDR_W-1:0]   addr;
  logic [NPORT-1:0][DATA_W-1:0]   wdata;
  logic [NPORT-1:0][DATA_W-1:0]   rdata;
  logic [NPORT-1:0]               en_n, en_p, sem_n, rw, oe_n;
  logic [NPORT-1:0]               busy_in, busy_out, wr_ok, rd_en, rvalid;

  assign addr    = {r_addr_i, l_addr_i};
  assign wdata   = {r_wdata_i, l_wdata_i};
  assign en_n    = {r_en_n_i, l_en_n_i};
  assign en_p    = {r_en_p_i, l_en_p_i};
  assign sem_n   = {r_sem_ni, l_sem_ni};
  assign rw      = {r_rw_i, l_rw_i};
  assign oe_n    = {r_oe_ni, l_oe_ni};
  assign busy_in = {r_busy_i, l_busy_i};

  for (genvar g = 0; g < NPORT; g++) begin : g_dec
    dpr_port_dec u_dec (
      .en_n_i (en_n[g]),
      .en_p_i (en_p[g]),
      .sem_ni (sem_n[g]),
      .rw_i   (rw[g]),
      .oe_ni  (oe_n[g]),
      .req_o  (req[g])
    );
    assign rd_en[g] = req[g].rd;
  end

  dpr_arb #(.AW(ADDR_W)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .master_i (master_i),
    .req_i    (req),
    .addr_i   (addr),
    .busy_i   (busy_in),
    .busy_o   (busy_out),
    .wr_ok_o  (wr_ok)
  );

  dpr_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_ok),
    .re_i     (rd_en),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .rvalid_o (rvalid)
  );

  assign l_busy_o   = busy_out[PL];
  assign r_busy_o   = busy_out[PR];
  assign l_rdata_o  = rdata[PL];
  assign r_rdata_o  = rdata[PR];
  assign l_rvalid_o = rvalid[PL];
  assign r_rvalid_o = rvalid[PR];
endmodule

// File: rtl/dpr_busy_chk.sv
module dpr_busy_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_i,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic [DATA_W-1:0] l_wdata_i,
  input logic              l_rw_i,
  input logic              l_oe_ni,
  input logic              l_en_n_i,
  input logic              l_en_p_i,
  input logic              l_sem_ni,
  input logic              l_busy_i,
  input logic              l_busy_o,
  input logic [DATA_W-1:0] l_rdata_o,
  input logic              l_rvalid_o,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic [DATA_W-1:0] r_wdata_i,
  input logic              r_rw_i,
  input logic              r_oe_ni,
  input logic              r_en_n_i,
  input logic              r_en_p_i,
  input logic              r_sem_ni,
  input logic              r_busy_i,
  input logic              r_busy_o,
  input logic [DATA_W-1:0] r_rdata_o,
  input logic              r_rvalid_o
);
  assert_desel_l_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!l_en_n_i && l_en_p_i) |=> !l_rvalid_o && l_rdata_o == '0);
  assert_desel_r_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!r_en_n_i && r_en_p_i) |=> !r_rvalid_o && r_rdata_o == '0);
  assert_read_l_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_en_n_i && l_en_p_i && l_sem_ni && l_rw_i && !l_oe_ni) |=> l_rvalid_o);
  assert_read_r_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_en_n_i && r_en_p_i && r_sem_ni && r_rw_i && !r_oe_ni) |=> r_rvalid_o);
  assert_oe_off_l_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_oe_ni |=> !l_rvalid_o);
  assert_oe_off_r_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_oe_ni |=> !r_rvalid_o);
  assert_no_sem_l_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_sem_ni |-> !r_busy_o && !l_busy_o);
  assert_shared_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_en_n_i && l_en_p_i && l_sem_ni && l_rw_i &&
     !r_en_n_i && r_en_p_i && r_sem_ni && r_rw_i) |-> !l_busy_o && !r_busy_o);
  assert_busy_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({l_busy_o, r_busy_o}));
  assert_slave_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !l_busy_o && !r_busy_o);
endmodule

bind dpr_busy_top dpr_busy_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_dpr_busy_top.sv
module tb_dpr_busy_top;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic master = 1'b1;
  always #2 clk = ~clk;

  // index 0 = left, 1 = right
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wdata [2];
  logic rw [2], oe_n [2], en_n [2], en_p [2], sem_n [2], bin [2];
  logic l_busy_o, r_busy_o, l_rvalid_o, r_rvalid_o;
  logic [DW-1:0] l_rdata_o, r_rdata_o;

  dpr_busy_top #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master),
    .l_addr_i(addr[0]), .l_wdata_i(wdata[0]), .l_rw_i(rw[0]), .l_oe_ni(oe_n[0]),
    .l_en_n_i(en_n[0]), .l_en_p_i(en_p[0]), .l_sem_ni(sem_n[0]), .l_busy_i(bin[0]),
    .l_busy_o(l_busy_o), .l_rdata_o(l_rdata_o), .l_rvalid_o(l_rvalid_o),
    .r_addr_i(addr[1]), .r_wdata_i(wdata[1]), .r_rw_i(rw[1]), .r_oe_ni(oe_n[1]),
    .r_en_n_i(en_n[1]), .r_en_p_i(en_p[1]), .r_sem_ni(sem_n[1]), .r_busy_i(bin[1]),
    .r_busy_o(r_busy_o), .r_rdata_o(r_rdata_o), .r_rvalid_o(r_rvalid_o)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [DW-1:0] mdl_mem [DEPTH];
  bit  mdl_prev_act [2];
  int  mdl_prev_addr [2];
  logic [DW-1:0] exp_rd [2];
  bit  exp_vld [2];
  string exp_tag = "reset";

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_ports();
    for (int p = 0; p < 2; p++) begin
      addr[p] = '0; wdata[p] = '0; rw[p] = 1'b1; oe_n[p] = 1'b1;
      en_n[p] = 1'b1; en_p[p] = 1'b0; sem_n[p] = 1'b1; bin[p] = 1'b0;
    end
  endtask

  task automatic set_port(int p, int a, int d, bit is_rd, bit oen, bit ena_n, bit ena_p, bit semn);
    addr[p] = a[AW-1:0]; wdata[p] = d[DW-1:0]; rw[p] = is_rd; oe_n[p] = oen;
    en_n[p] = ena_n; en_p[p] = ena_p; sem_n[p] = semn;
  endtask

  // one clock: check last results, apply inputs already set, check busy, advance model
  task automatic cyc(string tag);
    bit act [2], wr [2], rd [2], lose [2], wok [2], clash, held [2];
    check(exp_tag, "l_rvalid", int'(l_rvalid_o), int'(exp_vld[0]));
    check(exp_tag, "l_rdata", int'(l_rdata_o), int'(exp_rd[0]));
    check(exp_tag, "r_rvalid", int'(r_rvalid_o), int'(exp_vld[1]));
    check(exp_tag, "r_rdata", int'(r_rdata_o), int'(exp_rd[1]));
    #1;
    for (int p = 0; p < 2; p++) begin
      act[p] = (en_n[p] == 1'b0) && (en_p[p] == 1'b1) && (sem_n[p] == 1'b1);
      wr[p]  = act[p] && (rw[p] == 1'b0);
      rd[p]  = act[p] && (rw[p] == 1'b1) && (oe_n[p] == 1'b0);
      held[p] = mdl_prev_act[p] && (mdl_prev_addr[p] == int'(addr[p]));
      lose[p] = 1'b0;
    end
    clash = act[0] && act[1] && (addr[0] == addr[1]) && (wr[0] || wr[1]);
    if (clash) begin
      if (held[1] && !held[0]) lose[0] = 1'b1;
      else lose[1] = 1'b1;
    end
    for (int p = 0; p < 2; p++)
      wok[p] = wr[p] && (master ? !lose[p] : !bin[p]);
    check(tag, "l_busy", int'(l_busy_o), int'(master && lose[0]));
    check(tag, "r_busy", int'(r_busy_o), int'(master && lose[1]));
    for (int p = 0; p < 2; p++) begin
      exp_vld[p] = rd[p];
      exp_rd[p]  = rd[p] ? mdl_mem[addr[p]] : '0;
    end
    if (wok[1]) mdl_mem[addr[1]] = wdata[1];
    if (wok[0]) mdl_mem[addr[0]] = wdata[0];
    for (int p = 0; p < 2; p++) begin
      mdl_prev_act[p] = act[p];
      mdl_prev_addr[p] = int'(addr[p]);
    end
    exp_tag = tag;
    @(negedge clk);
  endtask

  task automatic read_back(string tag, int a);
    idle_ports();
    set_port(0, a, 0, 1, 0, 0, 1, 1);
    cyc(tag);
  endtask

  initial begin
    idle_ports();
    for (int p = 0; p < 2; p++) begin
      exp_rd[p] = '0; exp_vld[p] = 1'b0; mdl_prev_act[p] = 1'b0; mdl_prev_addr[p] = 0;
    end
    repeat (3) @(negedge clk);
    check("reset", "l_rvalid", int'(l_rvalid_o), 0);
    check("reset", "r_busy", int'(r_busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2: fill the array through both ports
    for (int i = 0; i < DEPTH / 2; i++) begin
      set_port(0, 2 * i, (2 * i * 7 + 3), 0, 1, 0, 1, 1);
      set_port(1, 2 * i + 1, ((2 * i + 1) * 7 + 3), 0, 1, 0, 1, 1);
      cyc("R2");
    end

    // R3: independent reads
    idle_ports();
    set_port(0, 10, 0, 1, 0, 0, 1, 1);
    set_port(1, 11, 0, 1, 0, 0, 1, 1);
    cyc("R3");
    set_port(0, 500, 0, 1, 0, 0, 1, 1);
    set_port(1, 77, 0, 1, 0, 0, 1, 1);
    cyc("R3");

    // R1: deselecting combinations, write attempt then read back
    idle_ports(); set_port(0, 20, 8'h5a, 0, 0, 1, 1, 1); cyc("R1");
    idle_ports(); set_port(0, 20, 8'h5b, 0, 0, 0, 0, 1); cyc("R1");
    idle_ports(); set_port(0, 20, 8'h5c, 0, 0, 1, 0, 1); cyc("R1");
    idle_ports(); set_port(1, 20, 0, 1, 0, 1, 1, 1); cyc("R1");
    read_back("R1", 20);

    // R4: output enable high blocks read data
    idle_ports(); set_port(0, 30, 0, 1, 1, 0, 1, 1); set_port(1, 31, 0, 1, 1, 0, 1, 1); cyc("R4");

    // R5: semaphore select low, no write
    idle_ports(); set_port(1, 40, 8'hee, 0, 0, 0, 1, 0); cyc("R5");
    idle_ports(); set_port(0, 40, 8'h11, 0, 1, 0, 1, 1); set_port(1, 40, 8'h22, 0, 1, 0, 1, 0); cyc("R5");
    read_back("R5", 40);

    // R6: shared read
    idle_ports(); cyc("R6");
    set_port(0, 50, 0, 1, 0, 0, 1, 1); set_port(1, 50, 0, 1, 0, 0, 1, 1); cyc("R6");

    // R8 + R12: simultaneous arrival, left write vs right read
    idle_ports(); cyc("R8");
    set_port(0, 60, 8'ha1, 0, 1, 0, 1, 1); set_port(1, 60, 0, 1, 0, 0, 1, 1); cyc("R12");
    read_back("R12", 60);
    // R8 + R9: both write simultaneously
    idle_ports(); cyc("R8");
    set_port(0, 61, 8'hb1, 0, 1, 0, 1, 1); set_port(1, 61, 8'hb2, 0, 1, 0, 1, 1); cyc("R8");
    read_back("R9", 61);

    // R7: left holds the word, right arrives later with a write
    idle_ports(); set_port(0, 70, 0, 1, 0, 0, 1, 1); cyc("R7");
    set_port(1, 70, 8'hc3, 0, 1, 0, 1, 1); cyc("R7");
    read_back("R9", 70);
    // R7 + R9: right holds, left arrives with a write and loses
    idle_ports(); set_port(1, 71, 0, 1, 0, 0, 1, 1); cyc("R7");
    set_port(0, 71, 8'hd4, 0, 1, 0, 1, 1); cyc("R7");
    set_port(0, 71, 8'hd5, 0, 1, 0, 1, 1); cyc("R9");
    read_back("R9", 71);

    // R11: master ignores busy inputs
    idle_ports(); set_port(1, 80, 8'h3c, 0, 1, 0, 1, 1); bin[1] = 1'b1; cyc("R11");
    read_back("R11", 80);

    // R10: slave mode
    master = 1'b0;
    idle_ports(); set_port(0, 90, 8'h91, 0, 1, 0, 1, 1); set_port(1, 90, 8'h92, 0, 1, 0, 1, 1); cyc("R10");
    read_back("R10", 90);
    idle_ports(); set_port(1, 91, 8'h44, 0, 1, 0, 1, 1); bin[1] = 1'b1; cyc("R10");
    read_back("R10", 91);
    idle_ports(); set_port(0, 92, 8'h55, 0, 1, 0, 1, 1); bin[0] = 1'b1;
    set_port(1, 92, 8'h66, 0, 1, 0, 1, 1); cyc("R10");
    read_back("R10", 92);

    // R7: random clashes on a small window
    for (int n = 0; n < 4000; n++) begin
      master = ($urandom_range(0, 3) != 0);
      for (int p = 0; p < 2; p++) begin
        set_port(p, $urandom_range(0, 3), $urandom_range(0, 255), $urandom_range(0, 1),
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
                 ($urandom_range(0, 5) != 0), ($urandom_range(0, 7) != 0));
        bin[p] = $urandom_range(0, 1);
      end
      cyc("R7");
    end
    idle_ports(); cyc("R7");
    cyc("R7");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule